// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Output Mutes

This block takes one serial bit on every rising edge of a fast bit clock and packs each run of sixteen consecutive bits into a parallel word. The bit that arrives first lands in the most significant position. Word boundaries come from a free-running phase counter that starts after reset. No alignment search is made. A one-cycle valid strobe marks each new word. The parallel output then holds its value for the rest of the word period.

From the same phase counter the block derives two clocks as registered outputs with a 50% duty cycle.

- The word clock runs at one sixteenth of the bit rate. It falls on the edge that loads a new word, so a downstream register clocked by it samples the word half a period later.
- The auxiliary clock runs either at the word rate or at a quarter of it, chosen by a select input.

Three active-low controls act as mutes. One forces the parallel data to zero. One holds the word clock low. One holds the auxiliary clock low.

All controls are registered on the bit clock. Clock mutes and the select change only at boundaries where the affected clock is already low, so a control change never shortens a pulse.

Top module: `serial_deser16`

## Requirements
- R1: After the sixteenth bit of a word is sampled, `dout` holds those sixteen bits with the first-sampled bit on bit 15 and the last-sampled bit on bit 0. This applies when the data mute is inactive.
- R2: `word_vld` is high for exactly one bit-clock cycle in every sixteen, on the same edge that loads `dout`. The first word covers the sixteen bits sampled from the first operating edge after reset.
- R3: Between two `word_vld` pulses, `dout` does not change.
- R4: The sampled value of `mute_dat_n` comes from the edge before a word load. If that value is 0, the load writes 16'h0000 into `dout` instead of the packed bits.
- R5: The word clock `wck_o` is high for 8 bit-clock cycles and low for 8. It is low in the cycle in which `word_vld` is high, and its rising edge comes 8 cycles after a word load.
- R6: `mute_wck_n` is sampled on each edge and loaded into the word-clock enable at each word boundary. While the loaded enable is 0, `wck_o` stays low.
- R7: The select `aux_fast` is loaded at each 64-cycle frame boundary. When the loaded value is 1, `aux_ck_o` equals the word clock. When it is 0, `aux_ck_o` is high for 32 cycles and low for 32, falling at the frame boundary.
- R8: `mute_aux_n` is loaded into the auxiliary enable at each 64-cycle frame boundary. While the loaded enable is 0, `aux_ck_o` stays low.
- R9: Driving `rst_n` low clears `dout`, `word_vld`, `wck_o` and `aux_ck_o` at once, without waiting for a clock edge. After `rst_n` rises, the first bit is sampled on the third rising edge. Both clock enables start at 0, so both clocks stay low until their first boundary.
- R10: Every high pulse on `wck_o` lasts exactly 8 cycles. Every high pulse on `aux_ck_o` lasts exactly 8 or 32 cycles, whatever the timing of control changes. Both clocks fall only on word boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a two-stage synchronizer |
| sdin | input | 1 | Serial data bit, sampled on each rising edge |
| mute_dat_n | input | 1 | Active-low data mute, forces zero words |
| mute_wck_n | input | 1 | Active-low word-clock mute |
| mute_aux_n | input | 1 | Active-low auxiliary-clock mute |
| aux_fast | input | 1 | Auxiliary clock rate select: 1 gives the word rate, 0 gives a quarter of it |
| dout | output | 16 | Parallel word, first-received bit on bit 15 |
| word_vld | output | 1 | One-cycle strobe marking a newly loaded word |
| wck_o | output | 1 | Word clock, bit rate divided by 16 |
| aux_ck_o | output | 1 | Auxiliary clock, word rate or word rate divided by 4 |

## Verification
The bench builds the block with the default ratio of 16 and an auxiliary divide of 4. With these values a full frame of both clocks repeats every 64 bit cycles, so a few thousand cycles cover many word boundaries, many frame boundaries, and every phase at which a control can change. Control toggles landing in the middle of high phases then show whether a pulse is ever truncated. A directed word checks bit ordering against a known pattern. A reset in the middle of a run checks that the asynchronous clear takes effect at once.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  localparam int DSR_RATIO_DFLT = 16;
  localparam int DSR_AUXDIV_DFLT = 4;

  // Sampled copy of the control pins, taken on every bit-clock edge.
  typedef struct packed {
    logic dat_en;
    logic wck_en;
    logic aux_en;
    logic aux_fast;
  } dsr_ctl_t;

endpackage

// File: rtl/dsr_rst_sync.sv
module dsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign rst_int_n = stg_q[1];
endmodule

// File: rtl/dsr_phase_ctr.sv
module dsr_phase_ctr #(
  parameter int CW = 4,
  parameter int AW = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic word_wrap,
  output logic frame_wrap,
  output logic nxt_word_hi,
  output logic nxt_frame_hi
);
  logic [AW-1:0] ph_q;
  logic [AW-1:0] ph_d;

  always_comb begin
    ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign word_wrap    = &ph_q[CW-1:0];
  assign frame_wrap   = &ph_q;
  assign nxt_word_hi  = ph_d[CW-1];
  assign nxt_frame_hi = ph_d[AW-1];
endmodule

// File: rtl/dsr_pack.sv
module dsr_pack #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdin,
  input  logic         wrap,
  input  logic         dat_en,
  output logic [W-1:0] dout,
  output logic         vld
);
  logic [W-2:0] sh_q, sh_d;
  logic [W-1:0] dout_d;
  logic         vld_d;

  always_comb begin
    sh_d   = {sh_q[W-3:0], sdin};
    vld_d  = wrap;
    dout_d = dout;
    if (wrap) dout_d = dat_en ? {sh_q, sdin} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      dout <= '0;
      vld  <= 1'b0;
    end else begin
      sh_q <= sh_d;
      dout <= dout_d;
      vld  <= vld_d;
    end
  end

  p_vld_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> $stable(dout));
  p_mute_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !$past(dat_en)) |-> (dout == '0));
endmodule

// File: rtl/dsr_clk_gate.sv
module dsr_clk_gate #(
  parameter bit SELECTABLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic en_in,
  input  logic sel_in,
  input  logic ph_fast,
  input  logic ph_slow,
  output logic clk_o
);
  logic en_q, en_d;
  logic sel_eff;
  logic out_d;

  generate
    if (SELECTABLE) begin : g_sel
      logic sel_q, sel_d;
      always_comb begin
        sel_d = load ? sel_in : sel_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= 1'b1;
        else        sel_q <= sel_d;
      end
      assign sel_eff = sel_d;
    end else begin : g_fix
      logic unused_sel;
      assign unused_sel = sel_in ^ ph_slow;
      assign sel_eff    = 1'b1;
    end
  endgenerate

  always_comb begin
    en_d  = load ? en_in : en_q;
    out_d = en_d & (sel_eff ? ph_fast : ph_slow);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      clk_o <= 1'b0;
    end else begin
      en_q  <= en_d;
      clk_o <= out_d;
    end
  end
endmodule

// File: rtl/serial_deser16.sv
module serial_deser16 #(
  parameter int RATIO   = dsr_pkg::DSR_RATIO_DFLT,
  parameter int AUX_DIV = dsr_pkg::DSR_AUXDIV_DFLT
) (
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic             sdin,
  input  logic             mute_dat_n,
  input  logic             mute_wck_n,
  input  logic             mute_aux_n,
  input  logic             aux_fast,
  output logic [RATIO-1:0] dout,
  output logic             word_vld,
  output logic             wck_o,
  output logic             aux_ck_o
);
  import dsr_pkg::*;

  localparam int CW = $clog2(RATIO);
  localparam int AW = $clog2(RATIO * AUX_DIV);

  logic     rst_int_n;
  logic     word_wrap, frame_wrap, nxt_word_hi, nxt_frame_hi;
  dsr_ctl_t ctl_q, ctl_d;

  dsr_rst_sync u_rst (
    .clk       (clk_bit),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  always_comb begin
    ctl_d.dat_en   = mute_dat_n;
    ctl_d.wck_en   = mute_wck_n;
    ctl_d.aux_en   = mute_aux_n;
    ctl_d.aux_fast = aux_fast;
  end

  always_ff @(posedge clk_bit or negedge rst_int_n) begin
    if (!rst_int_n) ctl_q <= '0;
    else            ctl_q <= ctl_d;
  end

  dsr_phase_ctr #(.CW(CW), .AW(AW)) u_ph (
    .clk          (clk_bit),
    .rst_n        (rst_int_n),
    .word_wrap    (word_wrap),
    .frame_wrap   (frame_wrap),
    .nxt_word_hi  (nxt_word_hi),
    .nxt_frame_hi (nxt_frame_hi)
  );

  dsr_pack #(.W(RATIO)) u_pack (
    .clk    (clk_bit),
    .rst_n  (rst_int_n),
    .sdin   (sdin),
    .wrap   (word_wrap),
    .dat_en (ctl_q.dat_en),
    .dout   (dout),
    .vld    (word_vld)
  );

  dsr_clk_gate #(.SELECTABLE(1'b0)) u_wck (
    .clk     (clk_bit),
    .rst_n   (rst_int_n),
    .load    (word_wrap),
    .en_in   (ctl_q.wck_en),
    .sel_in  (1'b1),
    .ph_fast (nxt_word_hi),
    .ph_slow (1'b0),
    .clk_o   (wck_o)
  );

  dsr_clk_gate #(.SELECTABLE(1'b1)) u_aux (
    .clk     (clk_bit),
    .rst_n   (rst_int_n),
    .load    (frame_wrap),
    .en_in   (ctl_q.aux_en),
    .sel_in  (ctl_q.aux_fast),
    .ph_fast (nxt_word_hi),
    .ph_slow (nxt_frame_hi),
    .clk_o   (aux_ck_o)
  );

  p_wck_low_on_load_r5: assert property (@(posedge clk_bit) disable iff (!rst_int_n)
    word_vld |-> !wck_o);
  p_wck_fall_aligned_r10: assert property (@(posedge clk_bit) disable iff (!rst_int_n)
    $fell(wck_o) |-> word_vld);
  p_aux_fall_aligned_r10: assert property (@(posedge clk_bit) disable iff (!rst_int_n)
    $fell(aux_ck_o) |-> word_vld);
  p_clr_r9: assert property (@(posedge clk_bit)
    !rst_n |-> (dout == '0 && !word_vld && !wck_o && !aux_ck_o));
endmodule

// File: tb/sim_serial_deser16.sv
module sim_serial_deser16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdin = 1'b0;
  logic        mute_dat_n = 1'b1;
  logic        mute_wck_n = 1'b1;
  logic        mute_aux_n = 1'b1;
  logic        aux_fast = 1'b1;
  logic [15:0] dout;
  logic        word_vld, wck_o, aux_ck_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_deser16 u0 (
    .clk_bit    (clk),
    .rst_n      (rst_n),
    .sdin       (sdin),
    .mute_dat_n (mute_dat_n),
    .mute_wck_n (mute_wck_n),
    .mute_aux_n (mute_aux_n),
    .aux_fast   (aux_fast),
    .dout       (dout),
    .word_vld   (word_vld),
    .wck_o      (wck_o),
    .aux_ck_o   (aux_ck_o)
  );

  // Behavioural reference model
  int          m_rel, m_ph;
  bit          m_q[$];
  logic [15:0] m_dout;
  logic        m_vld, m_wck, m_aux;
  logic        m_den, m_wen_s, m_aen_s, m_sel_s;
  logic        m_wen, m_aen, m_asel;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rel = 0; m_ph = 0; m_q.delete();
      m_dout = 0; m_vld = 0; m_wck = 0; m_aux = 0;
      m_den = 0; m_wen_s = 0; m_aen_s = 0; m_sel_s = 0;
      m_wen = 0; m_aen = 0; m_asel = 1;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1;
    end else begin
      int np;
      m_q.push_back(sdin);
      m_vld = 0;
      if (m_q.size() == 16) begin
        logic [15:0] w;
        for (int i = 0; i < 16; i++) w[15-i] = m_q[i];
        m_q.delete();
        m_dout = m_den ? w : 16'h0;
        m_vld = 1;
      end
      np = (m_ph + 1) % 64;
      if (m_ph % 16 == 15) m_wen = m_wen_s;
      m_wck = m_wen && (np % 16 >= 8);
      if (m_ph == 63) begin m_aen = m_aen_s; m_asel = m_sel_s; end
      m_aux = m_aen && (m_asel ? (np % 16 >= 8) : (np >= 32));
      m_den = mute_dat_n; m_wen_s = mute_wck_n;
      m_aen_s = mute_aux_n; m_sel_s = aux_fast;
      m_ph = np;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int   wrun, arun;
  logic wprev, aprev;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R1 dout vs model", dout, m_dout);
    chk("R2 word_vld vs model", word_vld, m_vld);
    chk("R5 wck_o vs model", wck_o, m_wck);
    chk("R7 aux_ck_o vs model", aux_ck_o, m_aux);
    if (!rst_n) begin
      wrun = 0; arun = 0; wprev = 0; aprev = 0;
    end else begin
      if (wprev && !wck_o) chk("R10 wck pulse width", wrun, 8);
      if (aprev && !aux_ck_o) chk("R10 aux pulse width 8 or 32", (arun == 8 || arun == 32), 1);
      wrun = (wck_o == wprev) ? wrun + 1 : 1;
      arun = (aux_ck_o == aprev) ? arun + 1 : 1;
      wprev = wck_o; aprev = aux_ck_o;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] pat;
    int hi, rises;
    wrun = 0; arun = 0; wprev = 0; aprev = 0;
    @(negedge clk);
    repeat (4) tick();
    chk("R9 reset dout", dout, 0);
    chk("R9 reset flags", {word_vld, wck_o, aux_ck_o}, 0);
    rst_n = 1'b1;
    // R9: clocks stay low until the first boundary
    for (int k = 0; k < 10; k++) begin
      sdin = $urandom; tick();
      chk("R9 wck low before first boundary", wck_o, 0);
    end
    for (int k = 0; k < 200; k++) begin sdin = $urandom; tick(); end

    // R1 directed word, then R3 hold
    pat = 16'hA5C3;
    while (m_ph % 16 != 0) begin sdin = $urandom; tick(); end
    for (int i = 0; i < 16; i++) begin sdin = pat[15-i]; tick(); end
    chk("R1 directed word msb first", dout, pat);
    chk("R2 strobe with directed word", word_vld, 1);
    for (int i = 0; i < 15; i++) begin
      sdin = ~sdin; tick();
      chk("R3 dout held between loads", dout, pat);
    end

    // R4 data mute
    mute_dat_n = 1'b0;
    repeat (40) begin sdin = $urandom; tick(); end
    chk("R4 muted word is zero", dout, 0);
    mute_dat_n = 1'b1;

    // R6 word clock mute
    mute_wck_n = 1'b0;
    repeat (20) begin sdin = $urandom; tick(); end
    for (int k = 0; k < 32; k++) begin
      sdin = $urandom; tick();
      chk("R6 muted wck low", wck_o, 0);
    end
    mute_wck_n = 1'b1;

    // R7 fast then slow auxiliary clock
    repeat (140) begin sdin = $urandom; tick(); end
    hi = 0; rises = 0;
    for (int k = 0; k < 128; k++) begin
      logic p; p = aux_ck_o; tick();
      hi += aux_ck_o; rises += (aux_ck_o && !p);
    end
    chk("R7 fast aux high count", hi, 64);
    chk("R7 fast aux rises", rises, 8);
    aux_fast = 1'b0;
    repeat (140) begin sdin = $urandom; tick(); end
    hi = 0; rises = 0;
    for (int k = 0; k < 128; k++) begin
      logic p; p = aux_ck_o; tick();
      hi += aux_ck_o; rises += (aux_ck_o && !p);
    end
    chk("R7 slow aux high count", hi, 64);
    chk("R7 slow aux rises", rises, 2);

    // R8 aux mute
    mute_aux_n = 1'b0;
    repeat (70) begin sdin = $urandom; tick(); end
    for (int k = 0; k < 64; k++) begin
      tick();
      chk("R8 muted aux low", aux_ck_o, 0);
    end
    mute_aux_n = 1'b1;

    // R10 random control toggling
    for (int k = 0; k < 2000; k++) begin
      sdin = $urandom;
      if ($urandom % 7 == 0) mute_dat_n = $urandom;
      if ($urandom % 5 == 0) mute_wck_n = $urandom;
      if ($urandom % 5 == 0) mute_aux_n = $urandom;
      if ($urandom % 9 == 0) aux_fast = $urandom;
      tick();
    end

    // R9 asynchronous reset in mid-run
    mute_dat_n = 1'b1; mute_wck_n = 1'b1; mute_aux_n = 1'b1; aux_fast = 1'b1;
    while (!wck_o || dout == 0) begin sdin = $urandom; tick(); end
    rst_n = 1'b0;
    #1;
    chk("R9 async clear dout", dout, 0);
    chk("R9 async clear flags", {word_vld, wck_o, aux_ck_o}, 0);
    repeat (3) tick();
    rst_n = 1'b1;
    for (int k = 0; k < 300; k++) begin sdin = $urandom; tick(); end

    summary();
    $finish;
  end
endmodule